// File: doc/BRIEF.md
# Cascaded Long-Range Capture Timer

This block joins an 8-bit timebase counter and a 12-bit up-counter into one 20-bit input-capture unit for measuring long pulses. The low counter advances on a prescaled tick enable. Each time it rolls over, it produces a one-cycle carry. In cascade mode that carry advances the high counter. In a second mode the high counter advances on every core clock instead. The high counter reloads from a programmable value when it overflows.

Each counter has a capture register, a sticky capture flag and an interrupt enable. A select bit decides what triggers the high capture: the low timer's capture pin, which gives one edge that latches a full 20-bit value, or the high timer's own pin. Software reaches all state through a byte-wide register port. Reading the high part of the 12-bit capture freezes the matching low byte, so that the two byte reads form one coherent value.

Top module: `cct_capture_timer`

## Requirements
- R1: After synchronous active-low reset, both counters, both capture registers, the reload value, the control bits and both flags are zero, and both interrupt outputs are low.
- R2: The low counter (readable at address 7) increments once per clock in which `tick_en` is high, holds when it is low, and wraps from 0xFF to 0x00 while emitting a one-cycle carry.
- R3: The high counter's clock mode is control bits [4:3]: 00 holds, 01 advances once per low-counter carry, 10 advances every clock, 11 holds.
- R4: When the high counter advances from 0xFFF it loads the reload value (address 5 holds bits [7:0], address 6 holds bits [11:8]). A reload of zero gives a plain wrap.
- R5: A rising edge on `lo_cap_pin`, seen after a two-flop synchronizer, copies the low counter into the low capture register (address 2) and sets the low flag (status bit 0). The copy happens on the third rising clock edge after the pin rises.
- R6: With the select bit (control bit 2) at 1, a `lo_cap_pin` edge also copies the high counter into the high capture register and sets the high flag (status bit 1) in the same cycle. With the select bit at 0, only a `hi_cap_pin` edge does that.
- R7: Read as {high capture, low capture}, the 20-bit value taken in cascade mode with `tick_en` held high differs between two captures by the number of clocks between the two pin edges, modulo 2^20.
- R8: Writing 1 to a status bit clears that flag, and writing 0 leaves it unchanged. When a capture falls in the same cycle as a clear, the flag ends up set.
- R9: `lo_irq` is high exactly while the low flag and control bit 0 are both set. `hi_irq` is high exactly while the high flag and control bit 1 are both set.
- R10: Reading address 3 returns high-capture bits [11:8] and freezes bits [7:0]. Address 4 returns that frozen byte, unchanged by later captures, until address 3 is read again.
- R11: A write that only changes the select bit sets no flag, whatever levels the two pins hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Prescaled enable for the low counter |
| lo_cap_pin | input | 1 | Asynchronous capture input of the low timer |
| hi_cap_pin | input | 1 | Asynchronous capture input of the high timer |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on address 3) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from address |
| lo_irq | output | 1 | Low capture interrupt |
| hi_irq | output | 1 | High capture interrupt |

## Verification
Two events can land in the same cycle. A capture edge can set a flag in the very cycle that software writes 1 to clear it. A capture can also rewrite the high register while a byte-wise read of it is in progress. The bench provokes the first by raising the pin and issuing the clear two falling edges later, so that the write and the capture share one clock edge; the flag must read back as set. It provokes the second by reading the high part, capturing again, and then reading the low byte, which must still hold the byte frozen by that first read. Capture deltas are compared against a bench-side model of the counters, including reload on overflow.

// File: rtl/cct_pkg.sv
// Shared constants for the cascaded capture timer: register map and
// high-counter clock modes. Assumes an 8-bit register data path.
package cct_pkg;
    localparam int DW = 8;
    localparam int AW = 3;

    typedef enum logic [1:0] {
        HCLK_HOLD    = 2'b00,
        HCLK_CASCADE = 2'b01,
        HCLK_CORE    = 2'b10,
        HCLK_OFF     = 2'b11
    } hclk_e;

    localparam logic [AW-1:0] A_CTRL    = 3'd0;
    localparam logic [AW-1:0] A_STAT    = 3'd1;
    localparam logic [AW-1:0] A_LOCAP   = 3'd2;
    localparam logic [AW-1:0] A_HICAP_H = 3'd3;
    localparam logic [AW-1:0] A_HICAP_L = 3'd4;
    localparam logic [AW-1:0] A_RLD_L   = 3'd5;
    localparam logic [AW-1:0] A_RLD_H   = 3'd6;
    localparam logic [AW-1:0] A_LOCNT   = 3'd7;
endpackage

// File: rtl/cct_edge_sync.sv
// Synchronizes an asynchronous pin through STAGES flops and flags its
// rising edge for one clock. Assumes STAGES >= 2.
module cct_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    logic [STAGES:0] sh;

    // Shift the pin through the synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], pin};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/cct_lo_timebase.sv
// Free-running W-bit timebase advanced by a prescaled enable; emits a
// one-cycle carry when it wraps. Assumes tick is synchronous to clk.
module cct_lo_timebase #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    output logic [W-1:0] cnt,
    output logic         carry
);
    localparam logic [W-1:0] TOP = '1;

    assign carry = tick && (cnt == TOP);

    // Count enabled ticks; natural wrap at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= cnt + 1'b1;
    end

    a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));
endmodule

// File: rtl/cct_hi_counter.sv
// W-bit up-counter with selectable advance source and reload on
// overflow. Assumes reload is stable while the counter runs.
module cct_hi_counter
    import cct_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  hclk_e        mode,
    input  logic         casc,
    input  logic [W-1:0] reload,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = '1;
    logic adv;

    // Pick the advance condition from the clock mode.
    always_comb begin
        unique case (mode)
            HCLK_CASCADE: adv = casc;
            HCLK_CORE:    adv = 1'b1;
            default:      adv = 1'b0;
        endcase
    end

    // Advance, reloading when leaving the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (adv) cnt <= (cnt == TOP) ? reload : cnt + 1'b1;
    end

    a_r3_hold_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == HCLK_HOLD || mode == HCLK_OFF) |=> $stable(cnt));
    a_r4_reload_on_top: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && cnt == TOP) |=> cnt == $past(reload));
endmodule

// File: rtl/cct_capture_timer.sv
// Cascaded 20-bit input-capture timer: low timebase plus high counter,
// selectable high-capture source, sticky W1C flags, interrupts and a
// byte register port. Assumes 9 <= HI_W <= 16 and LO_W <= 8.
module cct_capture_timer
    import cct_pkg::*;
#(
    parameter int LO_W = 8,
    parameter int HI_W = 12,
    parameter int SYNC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          lo_cap_pin,
    input  logic          hi_cap_pin,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          lo_irq,
    output logic          hi_irq
);
    localparam int HI_UP = HI_W - 8;

    logic            lo_rise, hi_rise, hi_trig, carry;
    logic [LO_W-1:0] lo_cnt, lo_cap;
    logic [HI_W-1:0] hi_cnt, hi_cap, reload;
    logic [7:0]      hi_lat;
    logic            lo_ie, hi_ie, cap_sel, lo_flag, hi_flag;
    hclk_e           mode;
    logic            wr_ctrl, wr_stat, rd_hih;
    logic [2:0]      unused_wbits;

    assign unused_wbits = reg_wdata[7:5];

    cct_edge_sync #(.STAGES(SYNC)) u_lo_sync (
        .clk(clk), .rst_n(rst_n), .pin(lo_cap_pin), .rise(lo_rise));
    cct_edge_sync #(.STAGES(SYNC)) u_hi_sync (
        .clk(clk), .rst_n(rst_n), .pin(hi_cap_pin), .rise(hi_rise));
    cct_lo_timebase #(.W(LO_W)) u_lo (
        .clk(clk), .rst_n(rst_n), .tick(tick_en), .cnt(lo_cnt), .carry(carry));
    cct_hi_counter #(.W(HI_W)) u_hi (
        .clk(clk), .rst_n(rst_n), .mode(mode), .casc(carry),
        .reload(reload), .cnt(hi_cnt));

    assign hi_trig = cap_sel ? lo_rise : hi_rise;
    assign wr_ctrl = reg_wr && reg_addr == A_CTRL;
    assign wr_stat = reg_wr && reg_addr == A_STAT;
    assign rd_hih  = reg_rd && reg_addr == A_HICAP_H;

    // Control and reload registers written from the register port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {lo_ie, hi_ie, cap_sel} <= '0;
            mode   <= HCLK_HOLD;
            reload <= '0;
        end else if (reg_wr) begin
            if (reg_addr == A_CTRL) begin
                lo_ie   <= reg_wdata[0];
                hi_ie   <= reg_wdata[1];
                cap_sel <= reg_wdata[2];
                mode    <= hclk_e'(reg_wdata[4:3]);
            end
            if (reg_addr == A_RLD_L) reload[7:0]      <= reg_wdata;
            if (reg_addr == A_RLD_H) reload[HI_W-1:8] <= reg_wdata[HI_UP-1:0];
        end
    end

    // Capture registers and sticky flags; a capture beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_cap <= '0; hi_cap <= '0; lo_flag <= 1'b0; hi_flag <= 1'b0;
        end else begin
            if (lo_rise) lo_cap <= lo_cnt;
            if (hi_trig) hi_cap <= hi_cnt;
            lo_flag <= lo_rise || (lo_flag && !(wr_stat && reg_wdata[0]));
            hi_flag <= hi_trig || (hi_flag && !(wr_stat && reg_wdata[1]));
        end
    end

    // Freeze the low byte of the high capture when its upper part is read.
    always_ff @(posedge clk) begin
        if (!rst_n)      hi_lat <= '0;
        else if (rd_hih) hi_lat <= hi_cap[7:0];
    end

    // Read-data mux over the register map.
    always_comb begin
        unique case (reg_addr)
            A_CTRL:    reg_rdata = {3'b000, mode, cap_sel, hi_ie, lo_ie};
            A_STAT:    reg_rdata = {6'b0, hi_flag, lo_flag};
            A_LOCAP:   reg_rdata = DW'(lo_cap);
            A_HICAP_H: reg_rdata = DW'(hi_cap[HI_W-1:8]);
            A_HICAP_L: reg_rdata = hi_lat;
            A_RLD_L:   reg_rdata = reload[7:0];
            A_RLD_H:   reg_rdata = DW'(reload[HI_W-1:8]);
            default:   reg_rdata = DW'(lo_cnt);
        endcase
    end

    assign lo_irq = lo_flag & lo_ie;
    assign hi_irq = hi_flag & hi_ie;

    a_r5_flag_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        lo_rise |=> lo_flag && lo_cap == $past(lo_cnt));
    a_r6_joint_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_sel && lo_rise) |=> lo_flag && hi_flag && hi_cap == $past(hi_cnt));
    a_r8_sticky_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_flag && !wr_stat) |=> lo_flag);
    a_r10_latch_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hih |=> $stable(hi_lat));
    a_r11_select_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !lo_rise && !hi_rise && !lo_flag && !hi_flag) |=> !lo_flag && !hi_flag);
endmodule

// File: tb/cct_capture_timer_bench.sv
module cct_capture_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0, lo_pin = 1'b0, hi_pin = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       lo_irq, hi_irq;
    int         errors = 0, checks = 0;
    int         ncnt = 0;
    bit         done = 0;

    always #4 clk = ~clk;
    always @(posedge clk) ncnt <= ncnt + 1;

    cct_capture_timer u_cct_capture_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .lo_cap_pin(lo_pin), .hi_cap_pin(hi_pin),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .lo_irq(lo_irq), .hi_irq(hi_irq));

    task automatic check(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output int d);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = int'(reg_rdata);
        @(posedge clk); @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_until(int t);
        while (ncnt < t) @(negedge clk);
    endtask

    task automatic pulse_lo();
        lo_pin = 1'b1; repeat (4) @(negedge clk);
        lo_pin = 1'b0; repeat (4) @(negedge clk);
    endtask

    task automatic pulse_hi();
        hi_pin = 1'b1; repeat (4) @(negedge clk);
        hi_pin = 1'b0; repeat (4) @(negedge clk);
    endtask

    task automatic read_hi(output int v);
        int h, l;
        rd(3'd3, h); rd(3'd4, l);
        v = (h << 8) | l;
    endtask

    function automatic int hi_model(int v, int n, int rl);
        for (int i = 0; i < n; i++) v = (v == 'hFFF) ? rl : v + 1;
        return v;
    endfunction

    task automatic t_reset();
        int d;
        rd(3'd2, d); check("R1 lo capture", d, 0);
        read_hi(d);  check("R1 hi capture", d, 0);
        rd(3'd1, d); check("R1 flags", d, 0);
        rd(3'd0, d); check("R1 control", d, 0);
        rd(3'd7, d); check("R1 lo counter", d, 0);
        check("R1 irqs", int'({lo_irq, hi_irq}), 0);
    endtask

    task automatic t_count_cascade();
        int d;
        wr(3'd0, 8'h0C);
        tick_en = 1'b1; repeat (5) @(negedge clk); tick_en = 1'b0;
        rd(3'd7, d); check("R2 five ticks", d, 5);
        repeat (3) @(negedge clk);
        rd(3'd7, d); check("R2 hold without tick", d, 5);
        tick_en = 1'b1; repeat (251) @(negedge clk); tick_en = 1'b0;
        rd(3'd7, d); check("R2 wrap to zero", d, 0);
        pulse_lo();
        rd(3'd2, d); check("R5 lo capture", d, 0);
        read_hi(d);  check("R3 cascade carry", d, 1);
        rd(3'd1, d); check("R6 both flags", d, 3);
        wr(3'd1, 8'h03);
        rd(3'd1, d); check("R8 clear", d, 0);
    endtask

    task automatic t_irq();
        wr(3'd0, 8'h0F);
        check("R9 idle irqs", int'({lo_irq, hi_irq}), 0);
        pulse_lo();
        check("R9 both irqs", int'({lo_irq, hi_irq}), 3);
        wr(3'd0, 8'h0D);
        check("R9 hi masked", int'({lo_irq, hi_irq}), 2);
        wr(3'd1, 8'h03);
        check("R9 cleared", int'({lo_irq, hi_irq}), 0);
    endtask

    task automatic t_select();
        int d;
        wr(3'd0, 8'h08);
        pulse_lo();
        rd(3'd1, d); check("R6 sel0 lo pin only", d, 1);
        wr(3'd1, 8'h01);
        pulse_hi();
        rd(3'd1, d); check("R6 sel0 hi pin", d, 2);
        wr(3'd1, 8'h02);
        lo_pin = 1'b1; repeat (4) @(negedge clk);
        wr(3'd1, 8'h03);
        wr(3'd0, 8'h0C); repeat (4) @(negedge clk);
        rd(3'd1, d); check("R11 select to 1", d, 0);
        wr(3'd0, 8'h08); repeat (4) @(negedge clk);
        rd(3'd1, d); check("R11 select to 0", d, 0);
        lo_pin = 1'b0; repeat (4) @(negedge clk);
    endtask

    task automatic t_race();
        int d;
        lo_pin = 1'b1;
        repeat (2) @(negedge clk);
        wr(3'd1, 8'h01);
        rd(3'd1, d); check("R8 capture wins over clear", d, 1);
        lo_pin = 1'b0; repeat (4) @(negedge clk);
        wr(3'd1, 8'h01);
        rd(3'd1, d); check("R8 later clear", d, 0);
    endtask

    task automatic t_delta();
        int t0, l1, h1, l2, h2;
        wr(3'd0, 8'h0C);
        tick_en = 1'b1;
        t0 = ncnt;
        lo_pin = 1'b1; wait_until(t0 + 4); lo_pin = 1'b0;
        wait_until(t0 + 8); rd(3'd2, l1); read_hi(h1);
        wait_until(t0 + 700); lo_pin = 1'b1;
        wait_until(t0 + 704); lo_pin = 1'b0;
        wait_until(t0 + 708); rd(3'd2, l2); read_hi(h2);
        tick_en = 1'b0;
        check("R7 20-bit delta", (((h2 << 8) | l2) - ((h1 << 8) | l1)) & 'hFFFFF, 700);
        wr(3'd1, 8'h03);
    endtask

    task automatic t_reload_latch();
        int t0, t1, v1, v2, v3, d;
        wr(3'd5, 8'h00); wr(3'd6, 8'h0F);
        wr(3'd0, 8'h14);
        t0 = ncnt;
        lo_pin = 1'b1; wait_until(t0 + 4); lo_pin = 1'b0;
        wait_until(t0 + 8); read_hi(v1);
        wait_until(t0 + 5000); lo_pin = 1'b1;
        wait_until(t0 + 5004); lo_pin = 1'b0;
        wait_until(t0 + 5008); read_hi(v2);
        check("R4 reload on overflow", v2, hi_model(v1, 5000, 'hF00));
        rd(3'd3, d);
        t1 = ncnt;
        lo_pin = 1'b1; wait_until(t1 + 4); lo_pin = 1'b0;
        wait_until(t1 + 8);
        v3 = hi_model(v2, t1 - (t0 + 5000), 'hF00);
        rd(3'd4, d); check("R10 frozen low byte", d, v2 & 'hFF);
        read_hi(d);  check("R10 refreshed value", d, v3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count_cascade();
        t_irq();
        t_select();
        t_race();
        t_delta();
        t_reload_latch();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule